// File: doc/BRIEF.md
# Serial Flash Flag Status Register

This block keeps the flag byte of a serial flash memory model aligned with the internal program/erase engine. The command decoder sends it one-cycle strobes for erase start, program start, suspend, resume and clear-flags. The engine reports the end of an operation, its erase pulses, the verify outcome and the conditions that make a program fail. From these events the block decides, cycle by cycle, which flag bits rise and which stay up. It also decides which single event brings each bit back down.

The readable byte has four fixed fields, which a read-out shifter decodes by position:
- bit 7: ready. It is the inverse of busy.
- bit 6: suspend pending/active.
- bit 5: erase failure.
- bit 4: program failure.
- bits 3..0: read as zero.

The write-in-progress output carries the busy level of the standard status register, so either register can be polled. The erase-pulse limit is a parameter, and the block counts pulses itself. A failure flag left over from an earlier erase makes the next erase fail at once.

Top module: `flash_flag_status`

## Requirements
- R1: After reset the byte reads 0x80 (ready=1, all other bits 0) and write-in-progress is 0.
- R2: Ready (bit 7) is always the inverse of write-in-progress. An accepted erase or program start makes write-in-progress 1 on the next cycle. An engine done strobe during a running operation returns it to 0 on the next cycle.
- R3: A suspend strobe while an operation runs sets bit 6 on the next cycle. Bit 6 stays 1 if the operation then completes without entering suspend mode. A suspend strobe while idle has no effect.
- R4: A resume strobe clears bit 6 on the next cycle. If an operation is held in suspend mode, it runs again (write-in-progress 1). Resume wins over suspend and suspend-acknowledge in the same cycle.
- R5: An engine suspend-acknowledge while bit 6 is set and an operation runs puts that operation on hold. Write-in-progress drops and bit 7 reads 1 with bit 6 still 1.
- R6: An erase that ends with verify failed after at least MAX_ERASE_PULSES pulses sets bit 5. A failed verify after fewer pulses, or a passed verify, leaves bit 5 at 0.
- R7: An erase start aimed at a protected region sets bit 5 on the next cycle and never becomes busy.
- R8: Bits 5 and 4 stay 1 until a clear-flags strobe, which zeroes them on the next cycle. Clear-flags leaves bits 7 and 6 unchanged.
- R9: An erase start while bit 5 is 1 is reported as failed: no busy period follows and bit 5 stays 1.
- R10: A program that ends with verify failed sets bit 4. So does a program that ends with the one-over-zero, high-voltage and 64-bit-multiple inputs all 1. A program start aimed at a protected region sets bit 4 without becoming busy.
- R11: A failure event in the same cycle as clear-flags leaves the failure bit set.
- R12: Bits 3..0 always read 0. Start strobes while busy or while an operation is held are ignored. When erase and program start arrive together, erase takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| erase_start_i | input | 1 | Erase command strobe (any erase size, any bus width) |
| program_start_i | input | 1 | Program command strobe |
| suspend_req_i | input | 1 | Program/erase suspend command strobe |
| resume_req_i | input | 1 | Program/erase resume command strobe |
| clear_flags_i | input | 1 | Clear-flag-status command strobe |
| region_protected_i | input | 1 | Target of the start strobe in this cycle is protected |
| op_done_i | input | 1 | Engine finished the running operation |
| suspend_ack_i | input | 1 | Engine has reached suspend mode |
| erase_pulse_i | input | 1 | Engine applied one erase pulse |
| verify_ok_i | input | 1 | Verify result, sampled with op_done_i |
| one_over_zero_i | input | 1 | Program tried to write 1 over 0, sampled with op_done_i |
| high_volt_i | input | 1 | High programming voltage applied, sampled with op_done_i |
| len_mult64_i | input | 1 | Program pattern is a multiple of 64 bits, sampled with op_done_i |
| fsr_o | output | 8 | Flag status byte |
| wip_o | output | 1 | Write-in-progress bit for the standard status register |

## Verification
The hardest state to reach is an operation held in suspend mode with bit 6 set. A sequence of its own has to walk through start, suspend, engine acknowledge and then resume, and the stimulus also tries a program start during the hold. A second hard case is an erase that fails only because the pulse limit was reached. The stimulus applies exactly the limit number of pulses before a failed verify. It contrasts this with an erase that has one pulse and a failed verify. Last, a failing erase end is paired with clear-flags in the same cycle.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  // Bit positions decoded by the read-out shifter
  localparam int unsigned FSR_W        = 8;
  localparam int unsigned RDY_BIT      = 7;
  localparam int unsigned SUSP_BIT     = 6;
  localparam int unsigned ERASE_FL_BIT = 5;
  localparam int unsigned PROG_FL_BIT  = 4;

  // Sticky failure flag indices
  localparam int unsigned N_FAIL  = 2;
  localparam int unsigned FL_ERA  = 0;
  localparam int unsigned FL_PRG  = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HELD = 2'd2
  } run_state_e;

  typedef enum logic {
    KIND_ERASE   = 1'b0,
    KIND_PROGRAM = 1'b1
  } op_kind_e;

endpackage

// File: rtl/ffs_rst_sync.sv
module ffs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ffs_op_tracker.sv
module ffs_op_tracker
  import ffs_pkg::*;
#(
  parameter int unsigned MAX_ERASE_PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic erase_start_i,
  input  logic program_start_i,
  input  logic resume_req_i,
  input  logic region_protected_i,
  input  logic op_done_i,
  input  logic suspend_ack_i,
  input  logic erase_pulse_i,
  input  logic verify_ok_i,
  input  logic one_over_zero_i,
  input  logic high_volt_i,
  input  logic len_mult64_i,
  input  logic erase_flag_i,
  input  logic susp_flag_i,
  output logic busy_o,
  output logic running_o,
  output logic erase_fail_o,
  output logic prog_fail_o
);

  localparam int unsigned CNT_W = $clog2(MAX_ERASE_PULSES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ERASE_PULSES);

  run_state_e      state_q, state_d;
  op_kind_e        kind_q, kind_d;
  logic            kind_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            pulses_spent;
  logic            prog_cond_fail;

  assign pulses_spent   = (cnt_q >= CNT_MAX);
  assign prog_cond_fail = !verify_ok_i ||
                          (one_over_zero_i && high_volt_i && len_mult64_i);

  // next-state process
  always_comb begin
    state_d      = state_q;
    kind_d       = kind_q;
    kind_en      = 1'b0;
    cnt_d        = cnt_q;
    cnt_en       = 1'b0;
    erase_fail_o = 1'b0;
    prog_fail_o  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (erase_start_i) begin
          if (region_protected_i || erase_flag_i) begin
            erase_fail_o = 1'b1;
          end else begin
            state_d = ST_RUN;
            kind_d  = KIND_ERASE;
            kind_en = 1'b1;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end else if (program_start_i) begin
          if (region_protected_i) begin
            prog_fail_o = 1'b1;
          end else begin
            state_d = ST_RUN;
            kind_d  = KIND_PROGRAM;
            kind_en = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (op_done_i) begin
          state_d = ST_IDLE;
          if (kind_q == KIND_ERASE) begin
            erase_fail_o = !verify_ok_i && pulses_spent;
          end else begin
            prog_fail_o = prog_cond_fail;
          end
        end else begin
          if (suspend_ack_i && susp_flag_i && !resume_req_i) begin
            state_d = ST_HELD;
          end
          if (kind_q == KIND_ERASE && erase_pulse_i && !pulses_spent) begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      ST_HELD: begin
        if (resume_req_i) begin
          state_d = ST_RUN;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_ERASE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (kind_en) begin
        kind_q <= kind_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o    = (state_q == ST_RUN);
  assign running_o = (state_q == ST_RUN);

endmodule

// File: rtl/ffs_sticky_flag.sv
module ffs_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  // set has priority over clear
  always_comb begin
    flag_d = flag_q;
    if (clr_i) begin
      flag_d = 1'b0;
    end
    if (set_i) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ffs_suspend_flag.sv
module ffs_suspend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_req_i,
  input  logic resume_req_i,
  input  logic running_i,
  output logic susp_o
);

  logic susp_q, susp_d;
  logic susp_en;

  always_comb begin
    susp_d  = susp_q;
    susp_en = 1'b0;
    if (resume_req_i) begin
      susp_d  = 1'b0;
      susp_en = 1'b1;
    end else if (suspend_req_i && running_i) begin
      susp_d  = 1'b1;
      susp_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
    end else if (susp_en) begin
      susp_q <= susp_d;
    end
  end

  assign susp_o = susp_q;

endmodule

// File: rtl/flash_flag_status.sv
module flash_flag_status
  import ffs_pkg::*;
#(
  parameter int unsigned MAX_ERASE_PULSES = 4,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       erase_start_i,
  input  logic       program_start_i,
  input  logic       suspend_req_i,
  input  logic       resume_req_i,
  input  logic       clear_flags_i,
  input  logic       region_protected_i,
  input  logic       op_done_i,
  input  logic       suspend_ack_i,
  input  logic       erase_pulse_i,
  input  logic       verify_ok_i,
  input  logic       one_over_zero_i,
  input  logic       high_volt_i,
  input  logic       len_mult64_i,
  output logic [7:0] fsr_o,
  output logic       wip_o
);

  logic              rst_int_n;
  logic              busy;
  logic              running;
  logic              susp_flag;
  logic [N_FAIL-1:0] fail_set;
  logic [N_FAIL-1:0] fail_flag;

  ffs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ffs_op_tracker #(.MAX_ERASE_PULSES(MAX_ERASE_PULSES)) u_tracker (
    .clk                (clk),
    .rst_n              (rst_int_n),
    .erase_start_i      (erase_start_i),
    .program_start_i    (program_start_i),
    .resume_req_i       (resume_req_i),
    .region_protected_i (region_protected_i),
    .op_done_i          (op_done_i),
    .suspend_ack_i      (suspend_ack_i),
    .erase_pulse_i      (erase_pulse_i),
    .verify_ok_i        (verify_ok_i),
    .one_over_zero_i    (one_over_zero_i),
    .high_volt_i        (high_volt_i),
    .len_mult64_i       (len_mult64_i),
    .erase_flag_i       (fail_flag[FL_ERA]),
    .susp_flag_i        (susp_flag),
    .busy_o             (busy),
    .running_o          (running),
    .erase_fail_o       (fail_set[FL_ERA]),
    .prog_fail_o        (fail_set[FL_PRG])
  );

  ffs_suspend_flag u_susp (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .suspend_req_i (suspend_req_i),
    .resume_req_i  (resume_req_i),
    .running_i     (running),
    .susp_o        (susp_flag)
  );

  for (genvar g = 0; g < N_FAIL; g++) begin : g_fail
    ffs_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_i  (fail_set[g]),
      .clr_i  (clear_flags_i),
      .flag_o (fail_flag[g])
    );
  end

  always_comb begin
    fsr_o               = '0;
    fsr_o[RDY_BIT]      = !busy;
    fsr_o[SUSP_BIT]     = susp_flag;
    fsr_o[ERASE_FL_BIT] = fail_flag[FL_ERA];
    fsr_o[PROG_FL_BIT]  = fail_flag[FL_PRG];
  end

  assign wip_o = busy;

endmodule

// File: rtl/ffs_checker.sv
module ffs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       erase_start_i,
  input logic       program_start_i,
  input logic       suspend_req_i,
  input logic       resume_req_i,
  input logic       clear_flags_i,
  input logic       op_done_i,
  input logic [7:0] fsr_o,
  input logic       wip_o
);

  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(erase_start_i || program_start_i || resume_req_i));

  // R2
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_o && op_done_i && !suspend_req_i) |=> !wip_o);

  // R3
  suspend_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_req_i && wip_o && !resume_req_i) |=> fsr_o[6]);

  // R4
  resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req_i |=> !fsr_o[6]);

  // R8
  erase_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_o[5] && !clear_flags_i) |=> fsr_o[5]);

  // R8
  prog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_o[4] && !clear_flags_i) |=> fsr_o[4]);

  // R8
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_flags_i && !wip_o && !erase_start_i && !program_start_i)
      |=> (fsr_o[5:4] == 2'b00));

  // R9
  leftover_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start_i && fsr_o[5] && !wip_o && !resume_req_i) |=> (!wip_o && fsr_o[5]));

endmodule

bind flash_flag_status ffs_checker u_ffs_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .erase_start_i   (erase_start_i),
  .program_start_i (program_start_i),
  .suspend_req_i   (suspend_req_i),
  .resume_req_i    (resume_req_i),
  .clear_flags_i   (clear_flags_i),
  .op_done_i       (op_done_i),
  .fsr_o           (fsr_o),
  .wip_o           (wip_o)
);

// File: tb/test_flash_flag_status.sv
`timescale 1ns/1ps
module test_flash_flag_status;

  localparam int unsigned MAXP = 3;

  logic clk;
  logic rst_n;
  logic [12:0] stim;
  logic [7:0]  fsr;
  logic        wip;
  int          checks;
  int          failures;
  bit          finished;

  // stimulus bit map
  localparam logic [12:0] V_ES   = 13'h1000;
  localparam logic [12:0] V_PS   = 13'h0800;
  localparam logic [12:0] V_SUS  = 13'h0400;
  localparam logic [12:0] V_RES  = 13'h0200;
  localparam logic [12:0] V_CLR  = 13'h0100;
  localparam logic [12:0] V_PROT = 13'h0080;
  localparam logic [12:0] V_DONE = 13'h0040;
  localparam logic [12:0] V_SACK = 13'h0020;
  localparam logic [12:0] V_PUL  = 13'h0010;
  localparam logic [12:0] V_VOK  = 13'h0008;
  localparam logic [12:0] V_OVR  = 13'h0004;
  localparam logic [12:0] V_HV   = 13'h0002;
  localparam logic [12:0] V_L64  = 13'h0001;
  localparam logic [12:0] V_NONE = 13'h0000;

  // {stimulus, expected fsr, expected wip, requirement number}
  localparam int NV = 48;
  localparam logic [25:0] TBL [NV] = '{
    {V_ES,               8'h00, 1'b1, 4'd2},  // R2 erase accepted
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_DONE|V_VOK,       8'h80, 1'b0, 4'd6},  // R6 verify passed
    {V_ES,               8'h00, 1'b1, 4'd2},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_DONE,             8'hA0, 1'b0, 4'd6},  // R6 limit reached, verify failed
    {V_ES,               8'hA0, 1'b0, 4'd9},  // R9 leftover flag
    {V_PS,               8'h20, 1'b1, 4'd2},
    {V_DONE|V_VOK|V_OVR|V_HV, 8'hA0, 1'b0, 4'd10}, // R10 length not multiple of 64
    {V_CLR,              8'h80, 1'b0, 4'd8},  // R8
    {V_PS,               8'h00, 1'b1, 4'd2},
    {V_DONE|V_VOK|V_OVR|V_HV|V_L64, 8'h90, 1'b0, 4'd10}, // R10 one over zero
    {V_CLR,              8'h80, 1'b0, 4'd8},
    {V_PS|V_PROT,        8'h90, 1'b0, 4'd10}, // R10 protected program
    {V_CLR,              8'h80, 1'b0, 4'd8},
    {V_ES|V_PROT,        8'hA0, 1'b0, 4'd7},  // R7 protected erase
    {V_CLR,              8'h80, 1'b0, 4'd8},
    {V_ES,               8'h00, 1'b1, 4'd2},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_DONE,             8'h80, 1'b0, 4'd6},  // R6 too few pulses
    {V_ES,               8'h00, 1'b1, 4'd2},
    {V_SUS,              8'h40, 1'b1, 4'd3},  // R3
    {V_SACK,             8'hC0, 1'b0, 4'd5},  // R5 held
    {V_PS,               8'hC0, 1'b0, 4'd12}, // R12 ignored while held
    {V_RES,              8'h00, 1'b1, 4'd4},  // R4 runs again
    {V_SUS,              8'h40, 1'b1, 4'd3},
    {V_DONE|V_VOK,       8'hC0, 1'b0, 4'd3},  // R3 completes before suspend
    {V_RES,              8'h80, 1'b0, 4'd4},  // R4 nothing held
    {V_SUS,              8'h80, 1'b0, 4'd3},  // R3 idle suspend ignored
    {V_PS,               8'h00, 1'b1, 4'd2},
    {V_PS|V_ES,          8'h00, 1'b1, 4'd12}, // R12 starts while busy ignored
    {V_DONE,             8'h90, 1'b0, 4'd10}, // R10 verify failed
    {V_ES,               8'h10, 1'b1, 4'd2},
    {V_CLR|V_PUL,        8'h00, 1'b1, 4'd8},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_PUL,              8'h00, 1'b1, 4'd6},
    {V_CLR|V_DONE,       8'hA0, 1'b0, 4'd11}, // R11 set wins over clear
    {V_CLR,              8'h80, 1'b0, 4'd8},
    {V_PS,               8'h00, 1'b1, 4'd2},
    {V_SUS,              8'h40, 1'b1, 4'd3},
    {V_CLR,              8'h40, 1'b1, 4'd8},  // R8 bit 6 untouched
    {V_SACK,             8'hC0, 1'b0, 4'd5},
    {V_CLR,              8'hC0, 1'b0, 4'd8},  // R8 bits 7 and 6 untouched
    {V_RES,              8'h00, 1'b1, 4'd4},
    {V_DONE|V_VOK,       8'h80, 1'b0, 4'd2}
  };

  flash_flag_status #(.MAX_ERASE_PULSES(MAXP)) i_flash_flag_status (
    .clk                (clk),
    .rst_n              (rst_n),
    .erase_start_i      (stim[12]),
    .program_start_i    (stim[11]),
    .suspend_req_i      (stim[10]),
    .resume_req_i       (stim[9]),
    .clear_flags_i      (stim[8]),
    .region_protected_i (stim[7]),
    .op_done_i          (stim[6]),
    .suspend_ack_i      (stim[5]),
    .erase_pulse_i      (stim[4]),
    .verify_ok_i        (stim[3]),
    .one_over_zero_i    (stim[2]),
    .high_volt_i        (stim[1]),
    .len_mult64_i       (stim[0]),
    .fsr_o              (fsr),
    .wip_o              (wip)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input int req, input logic [7:0] exp_fsr, input logic exp_wip);
    checks++;
    if (fsr !== exp_fsr || wip !== exp_wip || fsr[7] !== ~wip) begin
      failures++;
      $display("FAIL R%0d fsr=%h wip=%b expected fsr=%h wip=%b", req, fsr, wip, exp_fsr, exp_wip);
    end
  endtask

  task automatic do_reset();
    stim  = V_NONE;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    finished = 1'b0;
    @(negedge clk);
    do_reset();
    check(1, 8'h80, 1'b0); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      stim = TBL[i][25:13];
      @(posedge clk);
      @(negedge clk);
      check(int'(TBL[i][3:0]), TBL[i][12:5], TBL[i][4]);
    end
    stim = V_NONE;

    // R1 reset in the middle of a failing, suspended operation
    stim = V_ES;
    @(negedge clk);
    stim = V_SUS;
    @(negedge clk);
    stim = V_NONE;
    check(3, 8'h40, 1'b1); // R3 pending before reset
    do_reset();
    check(1, 8'h80, 1'b0); // R1

    // R12 erase and program together: erase taken
    stim = V_ES | V_PS;
    @(posedge clk);
    @(negedge clk);
    stim = V_PUL;
    @(negedge clk);
    stim = V_PUL;
    @(negedge clk);
    stim = V_PUL;
    @(negedge clk);
    stim = V_DONE;
    @(posedge clk);
    @(negedge clk);
    stim = V_NONE;
    check(12, 8'hA0, 1'b0); // R12 erase precedence shown by bit 5

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule